// File: doc/BRIEF.md
# Power-Down and Strap-Latch Sequencer

This block governs the power states of a clock-generator core. While power-on reset is held, it captures the levels on the shared configuration pins into a five-bit strap register. Once reset ends, it turns those pins around so that they drive clock outputs. The frequency code and the spread enable come either from those latched straps and the spread pin, or from register fields. A single select bit chooses between the two sources.

A power-down request arrives on an asynchronous active-low pin and is synchronized first. The sequencer then does three things in order. It parks the clock outputs low at a safe point: a falling edge of the internal clock taken while the reference clock is low. Next, after a hold time, it disables the PLL. After a second hold time it disables the crystal oscillator.

On release, the oscillator restarts first. The PLL is enabled after an oscillator start-up count. The outputs are released only after a PLL settle count. Analog behaviour is modelled by the enable outputs and these counters, all counted in reference-clock cycles. The stop inputs for the CPU and PCI clocks are synchronized. They have no effect while the outputs are parked.

Top module: `pdseq_top`

## Requirements
- R1: `pinOe` is 0 while `porN` is low. It becomes 1 at the first clock edge after `porN` rises and stays 1 from then on. Out of reset, `outEn`, `vcoEn` and `oscEn` are all 1.
- R2: The strap register holds the `strapIn` value sampled at the last rising clock edge with `porN` low. Later changes of `strapIn` and power-down cycles leave it unchanged. It is visible on `freqSel` when `regSel` is 0.
- R3: With `regSel`=1, `freqSel` equals `regFreq` and `spreadEn` equals `regSpread`. With `regSel`=0, `freqSel` is the strap register and `spreadEn` is the inverse of `spreadPinN`, delayed by the two-stage synchronizer.
- R4: After a synchronized power-down request, `outEn` stays 1 until a clock edge at which `intClkFall`=1 and `refLevel`=0 are sampled together. At that edge it falls.
- R5: `vcoEn` falls exactly HOLD_CYC cycles after `outEn` falls. `oscEn` falls exactly HOLD_CYC cycles after `vcoEn` falls.
- R6: While `outEn` is 0, `cpuRun` and `pciRun` are 0 whatever `cpuStopN` and `pciStopN` do. The block stays powered down while `pdN` is held low.
- R7: When `pdN` is released from the powered-down state, `oscEn` rises first. `vcoEn` rises exactly OSC_START_CYC cycles later. `outEn` rises exactly SETTLE_CYC cycles after that. The default SETTLE_CYC of 40000 stays under 3 ms at 14.318 MHz.
- R8: While `outEn` is 1, `cpuRun` follows `cpuStopN` and `pciRun` follows `pciStopN`, each through its two-stage synchronizer.
- R9: If `pdN` returns high before the output stop point has been reached, the block goes back to running without disabling any output, the PLL or the oscillator.
- R10: At every cycle, `outEn` implies `vcoEn`, and `vcoEn` implies `oscEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| porN | input | 1 | Power-on reset, active low |
| strapIn | input | 5 | Shared-pin levels, sampled during reset |
| pinOe | output | 1 | Shared pins drive clocks when 1 |
| pdN | input | 1 | Asynchronous power-down request, active low |
| cpuStopN | input | 1 | Asynchronous CPU clock stop, active low |
| pciStopN | input | 1 | Asynchronous PCI clock stop, active low |
| spreadPinN | input | 1 | Spread enable pin, active low |
| regSel | input | 1 | 1 selects register fields as the frequency/spread source |
| regFreq | input | 5 | Register frequency code |
| regSpread | input | 1 | Register spread enable |
| intClkFall | input | 1 | Falling-edge strobe of the internal clock |
| refLevel | input | 1 | Current level of the reference output clock |
| freqSel | output | 5 | Selected frequency code |
| spreadEn | output | 1 | Selected spread enable |
| outEn | output | 1 | Clock outputs running |
| cpuRun | output | 1 | CPU clocks running |
| pciRun | output | 1 | Stoppable PCI clocks running |
| vcoEn | output | 1 | PLL enable |
| oscEn | output | 1 | Crystal oscillator enable |

## Verification
On every cycle the assertions check the enable ordering. They check that the outputs stop only at a sampled safe point, that the PLL and the oscillator drop only after the stage above them, that the stop inputs stay silent while the outputs are parked, and that the strap register is frozen after reset. Only the bench scenarios can show the exact hold, start-up and settle distances, the strap value captured at reset, source selection, and the abort of a request before the stop point. These depend on values and cycle counts chosen by the stimulus.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_STOP_OUT,
    ST_VCO_OFF,
    ST_OSC_OFF,
    ST_DOWN,
    ST_OSC_START,
    ST_PLL_SETTLE
  } seqState_e;

  typedef enum logic [1:0] {
    CNT_HOLD,
    CNT_OSC,
    CNT_SETTLE
  } cntSel_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic    gateOff;
    logic    gateOn;
    logic    vcoOff;
    logic    vcoOn;
    logic    oscOff;
    logic    oscOn;
    logic    cntLoad;
    cntSel_e cntSel;
  } seqStrobe_t;

endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         porN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) stg[i] <= RST_VAL;
        else       stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) stg[i] <= RST_VAL;
        else       stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pdseq_ctrl.sv
module pdseq_ctrl
  import pdseq_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       pdReq,
  input  logic       intClkFall,
  input  logic       refLevel,
  input  logic       cntDone,
  output seqStrobe_t strb
);

  seqState_e state, stateNxt;
  logic      stopOk;

  // safe stop point: internal clock falling while the reference is low
  assign stopOk = intClkFall && !refLevel;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt    = state;
    strb        = '0;
    strb.cntSel = CNT_HOLD;
    unique case (state)
      ST_RUN: begin
        if (pdReq) stateNxt = ST_STOP_OUT;
      end
      ST_STOP_OUT: begin
        if (!pdReq) begin
          stateNxt = ST_RUN;
        end else if (stopOk) begin
          strb.gateOff = 1'b1;
          strb.cntLoad = 1'b1;
          strb.cntSel  = CNT_HOLD;
          stateNxt     = ST_VCO_OFF;
        end
      end
      ST_VCO_OFF: begin
        if (cntDone) begin
          strb.vcoOff  = 1'b1;
          strb.cntLoad = 1'b1;
          strb.cntSel  = CNT_HOLD;
          stateNxt     = ST_OSC_OFF;
        end
      end
      ST_OSC_OFF: begin
        if (cntDone) begin
          strb.oscOff = 1'b1;
          stateNxt    = ST_DOWN;
        end
      end
      ST_DOWN: begin
        if (!pdReq) begin
          strb.oscOn   = 1'b1;
          strb.cntLoad = 1'b1;
          strb.cntSel  = CNT_OSC;
          stateNxt     = ST_OSC_START;
        end
      end
      ST_OSC_START: begin
        if (cntDone) begin
          strb.vcoOn   = 1'b1;
          strb.cntLoad = 1'b1;
          strb.cntSel  = CNT_SETTLE;
          stateNxt     = ST_PLL_SETTLE;
        end
      end
      ST_PLL_SETTLE: begin
        if (cntDone) begin
          strb.gateOn = 1'b1;
          stateNxt    = ST_RUN;
        end
      end
      default: stateNxt = ST_RUN;
    endcase
  end

endmodule

// File: rtl/pdseq_dp.sv
module pdseq_dp
  import pdseq_pkg::*;
#(
  parameter int FS_W          = 5,
  parameter int HOLD_CYC      = 4,
  parameter int OSC_START_CYC = 2048,
  parameter int SETTLE_CYC    = 40000
) (
  input  logic            clk,
  input  logic            porN,
  input  seqStrobe_t      strb,
  input  logic [FS_W-1:0] strapIn,
  input  logic            regSel,
  input  logic [FS_W-1:0] regFreq,
  input  logic            regSpread,
  input  logic            spreadS,
  input  logic            cpuStopS,
  input  logic            pciStopS,
  output logic            cntDone,
  output logic            pinOe,
  output logic [FS_W-1:0] strapQ,
  output logic [FS_W-1:0] freqSel,
  output logic            spreadEn,
  output logic            outEn,
  output logic            cpuRun,
  output logic            pciRun,
  output logic            vcoEn,
  output logic            oscEn
);

  localparam int MAX_A = (HOLD_CYC > OSC_START_CYC) ? HOLD_CYC : OSC_START_CYC;
  localparam int MAX_C = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] OSC_LD    = CNT_W'(OSC_START_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  // strap capture: loads only while reset is held, never afterwards
  always_ff @(posedge clk) begin
    if (!porN) strapQ <= strapIn;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) pinOe <= 1'b0;
    else       pinOe <= 1'b1;
  end

  always_comb begin
    unique case (strb.cntSel)
      CNT_OSC:    loadVal = OSC_LD;
      CNT_SETTLE: loadVal = SETTLE_LD;
      default:    loadVal = HOLD_LD;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                 cnt <= '0;
    else if (strb.cntLoad)     cnt <= loadVal;
    else if (cnt != '0)        cnt <= cnt - 1'b1;
  end

  assign cntDone = (cnt == '0);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      outEn <= 1'b1;
      vcoEn <= 1'b1;
      oscEn <= 1'b1;
    end else begin
      if (strb.gateOff)     outEn <= 1'b0;
      else if (strb.gateOn) outEn <= 1'b1;
      if (strb.vcoOff)      vcoEn <= 1'b0;
      else if (strb.vcoOn)  vcoEn <= 1'b1;
      if (strb.oscOff)      oscEn <= 1'b0;
      else if (strb.oscOn)  oscEn <= 1'b1;
    end
  end

  assign freqSel  = regSel ? regFreq : strapQ;
  assign spreadEn = regSel ? regSpread : !spreadS;
  assign cpuRun   = outEn && cpuStopS;
  assign pciRun   = outEn && pciStopS;

endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
  import pdseq_pkg::*;
#(
  parameter int FS_W          = 5,
  parameter int SYNC_STAGES   = 2,
  parameter int HOLD_CYC      = 4,
  parameter int OSC_START_CYC = 2048,
  parameter int SETTLE_CYC    = 40000
) (
  input  logic            clk,
  input  logic            porN,
  input  logic [FS_W-1:0] strapIn,
  output logic            pinOe,
  input  logic            pdN,
  input  logic            cpuStopN,
  input  logic            pciStopN,
  input  logic            spreadPinN,
  input  logic            regSel,
  input  logic [FS_W-1:0] regFreq,
  input  logic            regSpread,
  input  logic            intClkFall,
  input  logic            refLevel,
  output logic [FS_W-1:0] freqSel,
  output logic            spreadEn,
  output logic            outEn,
  output logic            cpuRun,
  output logic            pciRun,
  output logic            vcoEn,
  output logic            oscEn
);

  logic [3:0]      syncQ;
  logic [FS_W-1:0] strapQ;
  logic            cntDone;
  seqStrobe_t      strb;

  // bit 3 power-down, 2 cpu stop, 1 pci stop, 0 spread pin (all idle high)
  pdseq_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) u_sync (
    .clk  (clk),
    .porN (porN),
    .d    ({pdN, cpuStopN, pciStopN, spreadPinN}),
    .q    (syncQ)
  );

  pdseq_ctrl u_ctrl (
    .clk        (clk),
    .porN       (porN),
    .pdReq      (!syncQ[3]),
    .intClkFall (intClkFall),
    .refLevel   (refLevel),
    .cntDone    (cntDone),
    .strb       (strb)
  );

  pdseq_dp #(
    .FS_W          (FS_W),
    .HOLD_CYC      (HOLD_CYC),
    .OSC_START_CYC (OSC_START_CYC),
    .SETTLE_CYC    (SETTLE_CYC)
  ) u_dp (
    .clk       (clk),
    .porN      (porN),
    .strb      (strb),
    .strapIn   (strapIn),
    .regSel    (regSel),
    .regFreq   (regFreq),
    .regSpread (regSpread),
    .spreadS   (syncQ[0]),
    .cpuStopS  (syncQ[2]),
    .pciStopS  (syncQ[1]),
    .cntDone   (cntDone),
    .pinOe     (pinOe),
    .strapQ    (strapQ),
    .freqSel   (freqSel),
    .spreadEn  (spreadEn),
    .outEn     (outEn),
    .cpuRun    (cpuRun),
    .pciRun    (pciRun),
    .vcoEn     (vcoEn),
    .oscEn     (oscEn)
  );

endmodule

// File: rtl/pdseq_chk.sv
module pdseq_chk #(
  parameter int FS_W = 5
) (
  input logic            clk,
  input logic            porN,
  input logic            pinOe,
  input logic [FS_W-1:0] strapQ,
  input logic            intClkFall,
  input logic            refLevel,
  input logic            outEn,
  input logic            vcoEn,
  input logic            oscEn,
  input logic            cpuRun,
  input logic            pciRun
);

  a_r1_pins_stay_out: assert property (@(posedge clk) disable iff (!porN)
    pinOe |=> pinOe);

  a_r2_strap_frozen: assert property (@(posedge clk) disable iff (!porN)
    pinOe |=> $stable(strapQ));

  a_r4_stop_point: assert property (@(posedge clk) disable iff (!porN)
    $fell(outEn) |-> $past(intClkFall && !refLevel));

  a_r5_vco_after_out: assert property (@(posedge clk) disable iff (!porN)
    $fell(vcoEn) |-> !outEn);

  a_r5_osc_after_vco: assert property (@(posedge clk) disable iff (!porN)
    $fell(oscEn) |-> !vcoEn);

  a_r6_stops_silent: assert property (@(posedge clk) disable iff (!porN)
    !outEn |-> (!cpuRun && !pciRun));

  a_r7_out_after_vco: assert property (@(posedge clk) disable iff (!porN)
    $rose(outEn) |-> $past(vcoEn));

  a_r10_out_order: assert property (@(posedge clk) disable iff (!porN)
    outEn |-> (vcoEn && oscEn));

  a_r10_vco_order: assert property (@(posedge clk) disable iff (!porN)
    vcoEn |-> oscEn);

endmodule

bind pdseq_top pdseq_chk #(.FS_W(FS_W)) u_chk (
  .clk        (clk),
  .porN       (porN),
  .pinOe      (pinOe),
  .strapQ     (strapQ),
  .intClkFall (intClkFall),
  .refLevel   (refLevel),
  .outEn      (outEn),
  .vcoEn      (vcoEn),
  .oscEn      (oscEn),
  .cpuRun     (cpuRun),
  .pciRun     (pciRun)
);

// File: tb/sim_pdseq_top.sv
`timescale 1ns/1ps
module sim_pdseq_top;

  localparam int HOLD   = 3;
  localparam int OSCC   = 5;
  localparam int SETTLE = 12;
  localparam int WD_CYC = 20000;

  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic [4:0] strapIn = 5'h13;
  logic       pdN = 1'b1, cpuStopN = 1'b1, pciStopN = 1'b1, spreadPinN = 1'b1;
  logic       regSel = 1'b0, regSpread = 1'b0;
  logic [4:0] regFreq = 5'h00;
  logic       intClkFall = 1'b0, refLevel = 1'b1;
  logic       pinOe, spreadEn, outEn, cpuRun, pciRun, vcoEn, oscEn;
  logic [4:0] freqSel;

  int  cyc = 0;
  int  nChecks = 0;
  int  nFails = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pdseq_top #(
    .HOLD_CYC(HOLD), .OSC_START_CYC(OSCC), .SETTLE_CYC(SETTLE)
  ) u0 (
    .clk(clk), .porN(porN), .strapIn(strapIn), .pinOe(pinOe), .pdN(pdN),
    .cpuStopN(cpuStopN), .pciStopN(pciStopN), .spreadPinN(spreadPinN),
    .regSel(regSel), .regFreq(regFreq), .regSpread(regSpread),
    .intClkFall(intClkFall), .refLevel(refLevel), .freqSel(freqSel),
    .spreadEn(spreadEn), .outEn(outEn), .cpuRun(cpuRun), .pciRun(pciRun),
    .vcoEn(vcoEn), .oscEn(oscEn)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    waitNeg(3);
    chk("R1 pinOe in reset", pinOe, 0);
    porN = 1'b1;
    waitNeg(1);
    chk("R1 pinOe after reset", pinOe, 1);
    chk("R1 outEn after reset", outEn, 1);
    chk("R1 vcoEn/oscEn after reset", {vcoEn, oscEn}, 3);
    chk("R2 strap captured", freqSel, 5'h13);
    strapIn = 5'h0A;
    waitNeg(3);
    chk("R2 strap ignores later pins", freqSel, 5'h13);
  endtask

  task automatic t_select;
    regSel = 1'b1; regFreq = 5'h1C; regSpread = 1'b1;
    waitNeg(1);
    chk("R3 register freq", freqSel, 5'h1C);
    chk("R3 register spread on", spreadEn, 1);
    regSpread = 1'b0;
    waitNeg(1);
    chk("R3 register spread off", spreadEn, 0);
    regSel = 1'b0; spreadPinN = 1'b0;
    waitNeg(3);
    chk("R3 pin spread on", spreadEn, 1);
    chk("R3 strap freq back", freqSel, 5'h13);
    spreadPinN = 1'b1;
    waitNeg(3);
    chk("R3 pin spread off", spreadEn, 0);
  endtask

  task automatic t_stops;
    cpuStopN = 1'b0;
    waitNeg(3);
    chk("R8 cpu stopped", cpuRun, 0);
    chk("R8 pci still runs", pciRun, 1);
    cpuStopN = 1'b1; pciStopN = 1'b0;
    waitNeg(3);
    chk("R8 cpu resumed", cpuRun, 1);
    chk("R8 pci stopped", pciRun, 0);
    pciStopN = 1'b1;
    waitNeg(3);
  endtask

  task automatic t_abort;
    pdN = 1'b0; intClkFall = 1'b1; refLevel = 1'b1;
    waitNeg(4);
    chk("R4 no stop while ref high", outEn, 1);
    intClkFall = 1'b0; refLevel = 1'b0;
    waitNeg(3);
    chk("R4 no stop without clock fall", outEn, 1);
    pdN = 1'b1; refLevel = 1'b1;
    waitNeg(6);
    chk("R9 abort keeps all enabled", {outEn, vcoEn, oscEn}, 7);
  endtask

  task automatic t_powerdown;
    int t0, tV, tO, tA, tB, tC;
    pdN = 1'b0;
    waitNeg(5);
    chk("R4 waits for stop point", outEn, 1);
    intClkFall = 1'b1; refLevel = 1'b0;
    waitNeg(1);
    intClkFall = 1'b0; refLevel = 1'b1;
    chk("R4 stopped at stop point", outEn, 0);
    t0 = cyc; tV = -1; tO = -1;
    for (int i = 0; i < 40; i++) begin
      if (i == 1) begin cpuStopN = 1'b1; pciStopN = 1'b1; end
      if (tV < 0 && !vcoEn) tV = cyc;
      if (tO < 0 && !oscEn) tO = cyc;
      @(negedge clk);
    end
    chk("R5 vco off after hold", tV - t0, HOLD);
    chk("R5 osc off after hold", tO - tV, HOLD);
    cpuStopN = 1'b0; pciStopN = 1'b1;
    waitNeg(3);
    chk("R6 cpu ignored in power-down", cpuRun, 0);
    chk("R6 pci ignored in power-down", pciRun, 0);
    cpuStopN = 1'b1;
    waitNeg(3);
    chk("R6 stays down while pdN low", {outEn, vcoEn, oscEn}, 0);
    chk("R2 strap kept through power-down", freqSel, 5'h13);
    pdN = 1'b1;
    tA = -1; tB = -1; tC = -1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tA < 0 && oscEn) tA = cyc;
      if (tB < 0 && vcoEn) tB = cyc;
      if (tC < 0 && outEn) tC = cyc;
    end
    chk("R7 oscillator restarted", oscEn, 1);
    chk("R7 vco after osc start", tB - tA, OSCC);
    chk("R7 outputs after settle", tC - tB, SETTLE);
    chk("R8 cpu runs after wake", cpuRun, 1);
    chk("R2 strap kept after wake", freqSel, 5'h13);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    t_reset();
    t_select();
    t_stops();
    t_abort();
    t_powerdown();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    wait (cyc >= WD_CYC);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WD_CYC);
      summary();
      $finish;
    end
  end

endmodule